// File: doc/BRIEF.md
# Audio Serial Master Clock Generator

This block produces the bit clock and the frame clock of a two-channel serial audio port when the port is the clock master. It derives both clocks from the converter master clock. Two mode pins pick single, double or quad speed, or hand the clock lines to an external master. A ratio input says whether the master clock runs at the base rate or at twice that rate. When it runs at twice the rate, a divide-by-two step is inserted first.

The frame clock runs at the output sample rate. The bit clock runs at 64 times that rate. Every frame clock transition falls on a bit clock falling edge.

In quad speed the bit clock period is only one and a half master clock periods. The block therefore runs on `edgeClk`, a clock at twice the master clock frequency. Each rising edge of `edgeClk` marks one master clock edge, rising or falling. All outputs are registers on that grid, so the fractional divide and the one-third duty come out glitch-free.

A companion `bitStrobe` gives the serial shifter a one-cycle marker for each new bit.

Top module: `audio_clk_gen`

## Requirements
- R1: With `rst` high at a rising `edgeClk` edge, `bitClk`, `frameClk`, `bitStrobe` and `driveEn` are all 0 after that edge.
- R2: `modeSel` 2'b00 selects single speed, 2'b01 double speed, 2'b10 quad speed, and 2'b11 external master. In external-master mode, `driveEn` is 0 and `bitClk`, `frameClk`, `bitStrobe` stay 0. In the three master modes, `driveEn` is 1.
- R3: With `fastRatio`=0, one bit clock period lasts 12, 6 or 3 `edgeClk` cycles in single, double or quad speed.
- R4: Each bit clock period starts low. The high time is 6, 3 or 1 `edgeClk` cycles, which gives 50%, 50% and 33% duty. The high time forms the tail of the period.
- R5: A frame is 64 bit clock periods. `frameClk` is 0 during periods 0 to 31 and 1 during periods 32 to 63.
- R6: `frameClk` changes only in the cycle where `bitClk` falls, which is the cycle where `bitStrobe` is 1. A restart is the one exception.
- R7: `bitStrobe` is a single-cycle pulse once per bit clock period, in the first low cycle of the period.
- R8: With `fastRatio`=1, every period and high time of R3 and R4 is doubled, and `bitStrobe` still lasts one cycle.
- R9: The first rising edge after reset or a restart begins bit period 0 of a frame. After that edge, `bitStrobe` is 1 and both clocks are 0.
- R10: A change of `modeSel` or `fastRatio` is seen at the next rising edge. That edge acts as a restart: all three clock outputs are 0 after it, and the following edge begins a fresh frame as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| edgeClk | input | 1 | Clock at twice the master clock rate, one edge per master clock edge |
| rst | input | 1 | Synchronous reset, active high |
| modeSel | input | 2 | Speed / master selection (R2 encoding) |
| fastRatio | input | 1 | 1 = master clock at twice the base ratio, engage divide-by-two |
| bitClk | output | 1 | Serial bit clock |
| frameClk | output | 1 | Frame (left/right) clock, low half first |
| bitStrobe | output | 1 | One-cycle marker at the start of each bit period |
| driveEn | output | 1 | 1 when the block drives the clock lines |

## Verification
Every output is a register updated on the `edgeClk` edge at which a divider tick occurs. The values for edge number e after a reset or restart are therefore fully determined by the integer tick index e, or e/2 in the doubled ratio. The bench takes that index modulo the period for the bit clock and the strobe, and divides it by the period for the frame clock. Each comparison is made at the falling `edgeClk` edge that follows rising edge e, half a cycle after the registers move.

The hold edge of a reset or configuration change is checked at its own falling edge, before edge 0 of the new frame.

// File: rtl/acg_pkg.sv
package acg_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_SLAVE  = 2'b11
  } spdMode_e;

  // strobes from the sequencing control to the clock datapath
  typedef struct packed {
    logic hold;       // restart / reset / external master: park everything
    logic tick;       // one divider step on the half-master-clock grid
    logic bitStart;   // this tick opens a new bit period (bit clock falls)
    logic highPhase;  // bit clock level for the phase being entered
  } genStrobe_t;

endpackage

// File: rtl/acg_ctrl.sv
module acg_ctrl
  import acg_pkg::*;
#(
  parameter int SINGLE_TICKS = 12,
  parameter int SINGLE_HIGH  = 6,
  parameter int DOUBLE_TICKS = 6,
  parameter int DOUBLE_HIGH  = 3,
  parameter int QUAD_TICKS   = 3,
  parameter int QUAD_HIGH    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       fastRatio,
  output genStrobe_t strb,
  output logic       masterOn
);

  localparam int PH_W = $clog2(SINGLE_TICKS + 1);
  localparam logic [PH_W-1:0] PH_PARK = '1;

  spdMode_e        speed;
  logic [2:0]      cfgQ;
  logic            cfgChanged;
  logic            idle;
  logic            preToggle;
  logic            tick;
  logic            wrap;
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseNext;
  logic [PH_W-1:0] periodLast;
  logic [PH_W-1:0] lowTicks;

  assign speed = spdMode_e'(modeSel);

  // per-speed period and low time on the half-master-clock grid
  always_comb begin
    case (speed)
      SPD_DOUBLE: begin
        periodLast = PH_W'(DOUBLE_TICKS - 1);
        lowTicks   = PH_W'(DOUBLE_TICKS - DOUBLE_HIGH);
      end
      SPD_QUAD: begin
        periodLast = PH_W'(QUAD_TICKS - 1);
        lowTicks   = PH_W'(QUAD_TICKS - QUAD_HIGH);
      end
      default: begin
        periodLast = PH_W'(SINGLE_TICKS - 1);
        lowTicks   = PH_W'(SINGLE_TICKS - SINGLE_HIGH);
      end
    endcase
  end

  // configuration tracking: any change forces a one-cycle restart
  always_ff @(posedge clk) begin
    cfgQ <= {modeSel, fastRatio};
  end

  assign cfgChanged = (cfgQ != {modeSel, fastRatio});
  assign idle       = rst || (speed == SPD_SLAVE) || cfgChanged;
  assign masterOn   = !rst && (speed != SPD_SLAVE);

  // pre-divider: every edge, or every second edge for the fast ratio
  always_ff @(posedge clk) begin
    if (idle) begin
      preToggle <= 1'b1;
    end else if (fastRatio) begin
      preToggle <= ~preToggle;
    end else begin
      preToggle <= 1'b1;
    end
  end

  assign tick = !idle && (!fastRatio || preToggle);

  // phase within one bit period
  assign wrap      = (phaseCnt >= periodLast);
  assign phaseNext = wrap ? '0 : phaseCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (idle) begin
      phaseCnt <= PH_PARK;
    end else if (tick) begin
      phaseCnt <= phaseNext;
    end
  end

  always_comb begin
    strb.hold      = idle;
    strb.tick      = tick;
    strb.bitStart  = tick && wrap;
    strb.highPhase = (phaseNext >= lowTicks);
  end

  // R3: the phase counter never leaves the period chosen for the mode
  p_phase_in_range_r3 : assert property (@(posedge clk) disable iff (rst)
    (tick && !idle) |=> (phaseCnt <= $past(periodLast)));

  // R8: with the doubled ratio two ticks are never adjacent
  p_fast_tick_spacing_r8 : assert property (@(posedge clk) disable iff (rst)
    (tick && fastRatio) |=> !tick);

endmodule

// File: rtl/acg_dp.sv
module acg_dp
  import acg_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  genStrobe_t strb,
  input  logic       masterOn,
  output logic       bitClk,
  output logic       frameClk,
  output logic       bitStrobe,
  output logic       driveEn
);

  localparam int BIT_W = $clog2(BITS_PER_FRAME);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_FRAME - 1);
  localparam logic [BIT_W-1:0] HALF_BIT = BIT_W'(BITS_PER_FRAME / 2);

  logic [BIT_W-1:0] bitCnt;
  logic [BIT_W-1:0] bitCntNext;

  assign bitCntNext = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;

  // bit position within the frame; parked on the last bit so the first
  // period after a restart is bit 0
  always_ff @(posedge clk) begin
    if (strb.hold) begin
      bitCnt <= LAST_BIT;
    end else if (strb.bitStart) begin
      bitCnt <= bitCntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.hold) begin
      bitClk <= 1'b0;
    end else if (strb.tick) begin
      bitClk <= strb.highPhase;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.hold) begin
      frameClk <= 1'b0;
    end else if (strb.bitStart) begin
      frameClk <= (bitCntNext >= HALF_BIT);
    end
  end

  always_ff @(posedge clk) begin
    bitStrobe <= !strb.hold && strb.bitStart;
    driveEn   <= masterOn;
  end

  // R2: a parked cycle leaves every clock output low
  p_idle_quiet_r2 : assert property (@(posedge clk) disable iff (rst)
    strb.hold |=> (!bitClk && !frameClk && !bitStrobe));

  // R6: the frame clock moves only together with a bit clock fall
  p_lrck_on_fall_r6 : assert property (@(posedge clk) disable iff (rst)
    (!$stable(frameClk) && !$past(strb.hold)) |-> bitStrobe);

  // R7: the strobe marks a low bit clock
  p_strobe_low_sclk_r7 : assert property (@(posedge clk) disable iff (rst)
    bitStrobe |-> !bitClk);

  // R5: frame clock low at bit 0, high at the middle bit
  p_frame_halves_r5 : assert property (@(posedge clk) disable iff (rst)
    (bitStrobe && (bitCnt == '0)) |-> !frameClk);

  p_frame_mid_r5 : assert property (@(posedge clk) disable iff (rst)
    (bitStrobe && (bitCnt == HALF_BIT)) |-> frameClk);

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64,
  parameter int SINGLE_TICKS   = 12,
  parameter int SINGLE_HIGH    = 6,
  parameter int DOUBLE_TICKS   = 6,
  parameter int DOUBLE_HIGH    = 3,
  parameter int QUAD_TICKS     = 3,
  parameter int QUAD_HIGH      = 1
) (
  input  logic       edgeClk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       fastRatio,
  output logic       bitClk,
  output logic       frameClk,
  output logic       bitStrobe,
  output logic       driveEn
);

  genStrobe_t strb;
  logic       masterOn;

  acg_ctrl #(
    .SINGLE_TICKS (SINGLE_TICKS),
    .SINGLE_HIGH  (SINGLE_HIGH),
    .DOUBLE_TICKS (DOUBLE_TICKS),
    .DOUBLE_HIGH  (DOUBLE_HIGH),
    .QUAD_TICKS   (QUAD_TICKS),
    .QUAD_HIGH    (QUAD_HIGH)
  ) u_ctrl (
    .clk       (edgeClk),
    .rst       (rst),
    .modeSel   (modeSel),
    .fastRatio (fastRatio),
    .strb      (strb),
    .masterOn  (masterOn)
  );

  acg_dp #(
    .BITS_PER_FRAME (BITS_PER_FRAME)
  ) u_dp (
    .clk       (edgeClk),
    .rst       (rst),
    .strb      (strb),
    .masterOn  (masterOn),
    .bitClk    (bitClk),
    .frameClk  (frameClk),
    .bitStrobe (bitStrobe),
    .driveEn   (driveEn)
  );

endmodule

// File: tb/audio_clk_gen_bench.sv
module audio_clk_gen_bench;

  logic       edgeClk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic       fastRatio = 1'b0;
  logic       bitClk, frameClk, bitStrobe, driveEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 edgeClk = ~edgeClk;

  audio_clk_gen u_audio_clk_gen (
    .edgeClk   (edgeClk),
    .rst       (rst),
    .modeSel   (modeSel),
    .fastRatio (fastRatio),
    .bitClk    (bitClk),
    .frameClk  (frameClk),
    .bitStrobe (bitStrobe),
    .driveEn   (driveEn)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic int ticksFor(input logic [1:0] m);
    return (m == 2'b00) ? 12 : (m == 2'b01) ? 6 : 3;
  endfunction

  function automatic int highFor(input logic [1:0] m);
    return (m == 2'b00) ? 6 : (m == 2'b01) ? 3 : 1;
  endfunction

  // start a configuration, either through reset or through a live change
  task automatic runCfg(input logic [1:0] m, input logic f, input bit viaReset);
    int p, h, d, n;
    logic prevFrame;
    p = ticksFor(m);
    h = highFor(m);
    d = f ? 2 : 1;
    n = 2 * 64 * p * d + 8;
    if (viaReset) begin
      rst = 1'b1;
      modeSel = m;
      fastRatio = f;
      repeat (3) @(negedge edgeClk);
      chk("R1", "bitClk", bitClk, 1'b0);
      chk("R1", "frameClk", frameClk, 1'b0);
      chk("R1", "bitStrobe", bitStrobe, 1'b0);
      chk("R1", "driveEn", driveEn, 1'b0);
      rst = 1'b0;
    end else begin
      modeSel = m;
      fastRatio = f;
      @(negedge edgeClk);
      chk("R10", "bitClk", bitClk, 1'b0);
      chk("R10", "frameClk", frameClk, 1'b0);
      chk("R10", "bitStrobe", bitStrobe, 1'b0);
    end
    prevFrame = 1'b0;
    for (int e = 0; e < n; e++) begin
      int k, ph, b;
      logic expBit, expFrame, expStb;
      @(negedge edgeClk);
      k = e / d;
      ph = k % p;
      b = (k / p) % 64;
      expBit = (ph >= p - h);
      expFrame = (b >= 32);
      expStb = ((e % d) == 0) && (ph == 0);
      if (e == 0) begin
        chk("R9", "bitStrobe", bitStrobe, 1'b1);
        chk("R9", "frameClk", frameClk, 1'b0);
      end
      if (f) chk("R8", "bitClk", bitClk, expBit);
      else if (expBit) chk("R4", "bitClk", bitClk, expBit);
      else chk("R3", "bitClk", bitClk, expBit);
      chk("R5", "frameClk", frameClk, expFrame);
      chk("R7", "bitStrobe", bitStrobe, expStb);
      chk("R2", "driveEn", driveEn, 1'b1);
      if (frameClk !== prevFrame) chk("R6", "strobe at frame edge", bitStrobe, 1'b1);
      prevFrame = frameClk;
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    runCfg(2'b00, 1'b0, 1'b1);
    runCfg(2'b01, 1'b0, 1'b0);
    runCfg(2'b10, 1'b0, 1'b0);
    runCfg(2'b10, 1'b1, 1'b0);
    runCfg(2'b00, 1'b1, 1'b1);
    runCfg(2'b01, 1'b1, 1'b0);
    // external master: clocks parked, lines released (R2)
    modeSel = 2'b11;
    fastRatio = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge edgeClk);
      chk("R2", "slave bitClk", bitClk, 1'b0);
      chk("R2", "slave frameClk", frameClk, 1'b0);
      chk("R2", "slave bitStrobe", bitStrobe, 1'b0);
      chk("R2", "slave driveEn", driveEn, 1'b0);
    end
    runCfg(2'b10, 1'b0, 1'b0);
    finish();
  end

  initial begin
    repeat (100000) @(posedge edgeClk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, got running expected done");
    finish();
  end

endmodule